// File: doc/BRIEF.md
# Next Fetch Address Predictor with Fast and Slow Direction Sources

This block owns the fetch program counter of an instruction front end and decides, every cycle, which address is fetched next. Two predictors of different speed look at each fetch address. A small tagged target cache answers in the same cycle with a stored target and a one-bit direction that remembers the last resolved outcome. A larger direct-mapped table of 2-bit saturating counters answers one cycle later. When the counter disagrees with the guess the target cache made for that address, it overrides the guess and the fetch issued in between is squashed.

Two redirect inputs from later stages also steer fetch. The decode stage can send a computed PC-relative target, and the execute stage sends the correct address after a misprediction. A fixed priority picks one source per cycle: execute correction, then decode redirect, then counter override, then target-cache taken target, then the sequential address. Both tables learn only from resolved branch outcomes reported by execute.

Top module: `nfa_predictor`

## Requirements
- R1: While `rst` is high, `fetch_pc` equals parameter `RESET_PC` (default 0) and `fetch_src` is 0. Reset empties the target cache. The counters start at 1, weakly not-taken, when the design is loaded.
- R2: When no source below applies, the next `fetch_pc` is the current one plus 4 and `fetch_src` is 0 (sequential).
- R3: The target cache is direct-mapped on `pc[5:2]` and tagged with `pc[31:6]`. It hits when the entry is valid and the tag matches. A hit whose direction bit is 1 makes the next `fetch_pc` the stored target with `fetch_src` 1. A tag mismatch is a miss.
- R4: A resolved taken branch writes its tag and target into the target cache and sets the direction bit. A resolved not-taken branch that hits clears only the direction bit. A not-taken branch that misses allocates nothing. A write is seen by lookups from the next cycle on.
- R5: The counter table is direct-mapped on `pc[9:2]`, so addresses that differ only above bit 9 share a counter. A resolved outcome moves the counter up when taken and down when not taken, saturating at 0 and 3. Bit 1 of the counter is its direction. An outcome presented in cycle u affects lookups made by fetches in cycle u+2 and later.
- R6: The counter for the address fetched in cycle t is compared in cycle t+1 with the taken or not-taken guess the target cache made for it in cycle t. On disagreement, the fetch in cycle t+2 is the override address with `fetch_src` 2, and the fetch of cycle t+1 is squashed. A not-taken counter overrides to the address plus 4.
- R7: A taken counter overrides only if the target cache hit that address in cycle t, using the stored target. With a miss, fetch continues sequentially.
- R8: A decode redirect makes the next `fetch_pc` equal to `dec_redir_tgt`, with `fetch_src` 3. It takes precedence over both predictors.
- R9: An execute correction makes the next `fetch_pc` equal to `exe_redir_tgt`, with `fetch_src` 4. It takes precedence over every other source.
- R10: Any redirect (source 2, 3 or 4) drops the pending counter comparison, so the fetch following a redirect is never overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_redir_vld | input | 1 | Decode-stage redirect request |
| dec_redir_tgt | input | AW | Decode-stage computed target |
| exe_redir_vld | input | 1 | Execute-stage correction request |
| exe_redir_tgt | input | AW | Correct fetch address after a mispredict |
| res_vld | input | 1 | A branch outcome is resolved this cycle |
| res_pc | input | AW | Address of the resolved branch |
| res_taken | input | 1 | Resolved direction, 1 = taken |
| res_tgt | input | AW | Resolved target address |
| fetch_pc | output | AW | Registered fetch address |
| fetch_src | output | 3 | Source of `fetch_pc`: 0 seq, 1 cache, 2 override, 3 decode, 4 execute |

## Verification
A redirect or a target-cache hit shows on `fetch_pc` one clock after the cycle it is presented or looked up. A counter override shows two clocks after the fetch it concerns. Training reaches the target cache one clock after the outcome and reaches the counters for fetches two clocks after it. The bench keeps a reference model that it steps once per rising edge, applying these delays to inputs held stable since the previous falling edge. It compares both outputs at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_FAST = 3'd1,
    SRC_SLOW = 3'd2,
    SRC_DEC  = 3'd3,
    SRC_EXE  = 3'd4
  } nfa_src_e;

  // saturating two-bit counter step
  function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
    logic [1:0] res;
    if (taken) res = (cur == 2'd3) ? 2'd3 : cur + 2'd1;
    else       res = (cur == 2'd0) ? 2'd0 : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/nfa_tgt_cache.sv
module nfa_tgt_cache #(
  parameter int AW    = 32,
  parameter int IDX_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] lk_pc,
  output logic          lk_hit,
  output logic          lk_dir,
  output logic [AW-1:0] lk_tgt,
  input  logic          wr_vld,
  input  logic [AW-1:0] wr_pc,
  input  logic          wr_taken,
  input  logic [AW-1:0] wr_tgt
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = AW - 2 - IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] dir_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [AW-1:0]    tgt_mem [DEPTH];

  logic [IDX_W-1:0] lk_idx, w_idx;
  logic [TAG_W-1:0] lk_tag, w_tag;
  logic             w_hit;

  assign lk_idx = lk_pc[2 +: IDX_W];
  assign lk_tag = lk_pc[AW-1 -: TAG_W];
  assign w_idx  = wr_pc[2 +: IDX_W];
  assign w_tag  = wr_pc[AW-1 -: TAG_W];

  // distributed memory, asynchronous read for a same-cycle answer
  assign lk_hit = vld_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_dir = dir_q[lk_idx];
  assign lk_tgt = tgt_mem[lk_idx];
  assign w_hit  = vld_q[w_idx] && (tag_mem[w_idx] == w_tag);

  always_ff @(posedge clk) begin
    if (wr_vld && wr_taken) begin
      tag_mem[w_idx] <= w_tag;
      tgt_mem[w_idx] <= wr_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      dir_q <= '0;
    end else if (wr_vld) begin
      if (wr_taken) begin
        vld_q[w_idx] <= 1'b1;
        dir_q[w_idx] <= 1'b1;
      end else if (w_hit) begin
        dir_q[w_idx] <= 1'b0;
      end
    end
  end

  // R4
  alloc_on_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && wr_taken) |=> (vld_q[$past(w_idx)] && dir_q[$past(w_idx)]));

endmodule

// File: rtl/nfa_ctr_table.sv
module nfa_ctr_table import nfa_pkg::*; #(
  parameter int AW    = 32,
  parameter int IDX_W = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_pc,
  output logic [1:0]    rd_ctr,
  input  logic          tr_vld,
  input  logic [AW-1:0] tr_pc,
  input  logic          tr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] ctr_mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) ctr_mem[i] = 2'b01;
  end

  logic [IDX_W-1:0] rd_idx, tr_idx;
  assign rd_idx = rd_pc[2 +: IDX_W];
  assign tr_idx = tr_pc[2 +: IDX_W];

  // lookup port: registered read, answer one cycle after the fetch
  always_ff @(posedge clk) begin
    rd_ctr <= ctr_mem[rd_idx];
  end

  // training: read the old value, then write the stepped value
  logic             s1_vld, s1_tk;
  logic [IDX_W-1:0] s1_idx;
  logic [1:0]       s1_rd;
  logic             wq_vld;
  logic [IDX_W-1:0] wq_idx;
  logic [1:0]       wq_val;
  logic [1:0]       old_val, wr_val;

  always_ff @(posedge clk) begin
    s1_rd  <= ctr_mem[tr_idx];
    s1_idx <= tr_idx;
    s1_tk  <= tr_taken;
    wq_idx <= s1_idx;
    wq_val <= wr_val;
    if (rst) begin
      s1_vld <= 1'b0;
      wq_vld <= 1'b0;
    end else begin
      s1_vld <= tr_vld;
      wq_vld <= s1_vld;
    end
  end

  // forward the write of the previous cycle, whose read was stale
  assign old_val = (wq_vld && (wq_idx == s1_idx)) ? wq_val : s1_rd;
  assign wr_val  = ctr_step(old_val, s1_tk);

  always_ff @(posedge clk) begin
    if (s1_vld) ctr_mem[s1_idx] <= wr_val;
  end

  // R5
  ctr_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_tk && wq_vld && (wq_idx == s1_idx)) |-> (wr_val >= wq_val));

endmodule

// File: rtl/nfa_next_sel.sv
module nfa_next_sel import nfa_pkg::*; #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_pc,
  input  logic          exe_vld,
  input  logic [AW-1:0] exe_tgt,
  input  logic          dec_vld,
  input  logic [AW-1:0] dec_tgt,
  input  logic          ovr_vld,
  input  logic [AW-1:0] ovr_tgt,
  input  logic          fast_tk,
  input  logic [AW-1:0] fast_tgt,
  output logic [AW-1:0] nxt_pc,
  output nfa_src_e      nxt_src,
  output logic          redir
);

  localparam logic [AW-1:0] STEP = AW'(4);

  always_comb begin
    nxt_pc  = cur_pc + STEP;
    nxt_src = SRC_SEQ;
    if (exe_vld) begin
      nxt_pc  = exe_tgt;
      nxt_src = SRC_EXE;
    end else if (dec_vld) begin
      nxt_pc  = dec_tgt;
      nxt_src = SRC_DEC;
    end else if (ovr_vld) begin
      nxt_pc  = ovr_tgt;
      nxt_src = SRC_SLOW;
    end else if (fast_tk) begin
      nxt_pc  = fast_tgt;
      nxt_src = SRC_FAST;
    end
  end

  assign redir = exe_vld || dec_vld || ovr_vld;

endmodule

// File: rtl/nfa_predictor.sv
module nfa_predictor import nfa_pkg::*; #(
  parameter int              AW         = 32,
  parameter int              FAST_IDX_W = 4,
  parameter int              CTR_IDX_W  = 8,
  parameter logic [AW-1:0]   RESET_PC   = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_redir_vld,
  input  logic [AW-1:0] dec_redir_tgt,
  input  logic          exe_redir_vld,
  input  logic [AW-1:0] exe_redir_tgt,
  input  logic          res_vld,
  input  logic [AW-1:0] res_pc,
  input  logic          res_taken,
  input  logic [AW-1:0] res_tgt,
  output logic [AW-1:0] fetch_pc,
  output logic [2:0]    fetch_src
);

  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] pc_q;
  nfa_src_e      src_q;
  logic          run_q;

  // same-cycle target cache answer for the current fetch
  logic          f_hit, f_dir;
  logic [AW-1:0] f_tgt;

  nfa_tgt_cache #(.AW(AW), .IDX_W(FAST_IDX_W)) i_fast (
    .clk(clk), .rst(rst),
    .lk_pc(pc_q), .lk_hit(f_hit), .lk_dir(f_dir), .lk_tgt(f_tgt),
    .wr_vld(res_vld), .wr_pc(res_pc), .wr_taken(res_taken), .wr_tgt(res_tgt)
  );

  // counter answer for the previous fetch
  logic [1:0] ctr_rd;

  nfa_ctr_table #(.AW(AW), .IDX_W(CTR_IDX_W)) i_slow (
    .clk(clk), .rst(rst),
    .rd_pc(pc_q), .rd_ctr(ctr_rd),
    .tr_vld(res_vld), .tr_pc(res_pc), .tr_taken(res_taken)
  );

  // what the fast side guessed for the previous fetch
  logic          pend_vld, pend_hit, pend_dir;
  logic [AW-1:0] pend_pc, pend_tgt;
  logic          slow_tk, fast_was_tk, ovr_vld;
  logic [AW-1:0] ovr_tgt;

  assign slow_tk     = ctr_rd[1];
  assign fast_was_tk = pend_hit && pend_dir;
  assign ovr_vld     = pend_vld &&
                       ((slow_tk && !fast_was_tk && pend_hit) ||
                        (!slow_tk && fast_was_tk));
  assign ovr_tgt     = slow_tk ? pend_tgt : pend_pc + STEP;

  logic [AW-1:0] nxt_pc;
  nfa_src_e      nxt_src;
  logic          redir;

  nfa_next_sel #(.AW(AW)) i_sel (
    .cur_pc(pc_q),
    .exe_vld(exe_redir_vld), .exe_tgt(exe_redir_tgt),
    .dec_vld(dec_redir_vld), .dec_tgt(dec_redir_tgt),
    .ovr_vld(ovr_vld), .ovr_tgt(ovr_tgt),
    .fast_tk(f_hit && f_dir), .fast_tgt(f_tgt),
    .nxt_pc(nxt_pc), .nxt_src(nxt_src), .redir(redir)
  );

  always_ff @(posedge clk) begin
    pend_pc  <= pc_q;
    pend_hit <= f_hit;
    pend_dir <= f_dir;
    pend_tgt <= f_tgt;
    if (rst) begin
      pc_q     <= RESET_PC;
      src_q    <= SRC_SEQ;
      pend_vld <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      pc_q     <= nxt_pc;
      src_q    <= nxt_src;
      pend_vld <= !redir;
      run_q    <= 1'b1;
    end
  end

  assign fetch_pc  = pc_q;
  assign fetch_src = src_q;

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && src_q == SRC_SEQ) |-> (pc_q == $past(pc_q) + STEP));

  // R8
  dec_redir_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_redir_vld && !exe_redir_vld) |=>
      (src_q == SRC_DEC && pc_q == $past(dec_redir_tgt)));

  // R9
  exe_redir_chk: assert property (@(posedge clk) disable iff (rst)
    exe_redir_vld |=> (src_q == SRC_EXE && pc_q == $past(exe_redir_tgt)));

  // R10
  no_stale_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    (src_q == SRC_EXE || src_q == SRC_DEC || src_q == SRC_SLOW) |=>
      (src_q != SRC_SLOW));

endmodule

// File: tb/test_nfa_predictor.sv
module test_nfa_predictor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_redir_vld = 1'b0;
  logic [31:0] dec_redir_tgt = '0;
  logic        exe_redir_vld = 1'b0;
  logic [31:0] exe_redir_tgt = '0;
  logic        res_vld = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_tgt = '0;
  logic [31:0] fetch_pc;
  logic [2:0]  fetch_src;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nfa_predictor i_nfa_predictor (
    .clk(clk), .rst(rst),
    .dec_redir_vld(dec_redir_vld), .dec_redir_tgt(dec_redir_tgt),
    .exe_redir_vld(exe_redir_vld), .exe_redir_tgt(exe_redir_tgt),
    .res_vld(res_vld), .res_pc(res_pc), .res_taken(res_taken), .res_tgt(res_tgt),
    .fetch_pc(fetch_pc), .fetch_src(fetch_src)
  );

  // reference model state
  bit          m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];
  bit          m_dir [16];
  logic [1:0]  m_ctr [256];
  bit          dl_vld, dl_tk;
  logic [7:0]  dl_idx;
  logic [31:0] m_pc;
  logic [2:0]  m_src;
  bit          p_vld, p_hit, p_dir;
  logic [31:0] p_pc, p_tgt;
  logic [1:0]  slow_q;

  function automatic logic [1:0] sat(input logic [1:0] c, input bit tk);
    if (tk) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3 R4";
      3'd2: return "R5 R6 R7";
      3'd3: return "R8 R10";
      default: return "R9 R10";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
    dl_vld = 0; p_vld = 0; m_pc = 32'h0; m_src = 3'd0;
  endtask

  task automatic model_step();
    logic [3:0]  fi, wi;
    bit          hit, dir, whit, ovr, fw;
    logic [31:0] tgt, otgt, npc;
    logic [2:0]  nsrc;
    fi   = m_pc[5:2];
    hit  = m_vld[fi] && (m_tag[fi] == m_pc[31:6]);
    dir  = m_dir[fi];
    tgt  = m_tgt[fi];
    fw   = p_hit && p_dir;
    ovr  = 0; otgt = '0;
    if (p_vld && slow_q[1] && !fw && p_hit) begin ovr = 1; otgt = p_tgt; end
    if (p_vld && !slow_q[1] && fw) begin ovr = 1; otgt = p_pc + 4; end
    if (exe_redir_vld)      begin npc = exe_redir_tgt; nsrc = 3'd4; end
    else if (dec_redir_vld) begin npc = dec_redir_tgt; nsrc = 3'd3; end
    else if (ovr)           begin npc = otgt;          nsrc = 3'd2; end
    else if (hit && dir)    begin npc = tgt;           nsrc = 3'd1; end
    else                    begin npc = m_pc + 4;      nsrc = 3'd0; end
    p_vld = !(exe_redir_vld || dec_redir_vld || ovr);
    p_pc = m_pc; p_hit = hit; p_dir = dir; p_tgt = tgt;
    slow_q = m_ctr[m_pc[9:2]];
    if (dl_vld) m_ctr[dl_idx] = sat(m_ctr[dl_idx], dl_tk);
    dl_vld = res_vld; dl_idx = res_pc[9:2]; dl_tk = res_taken;
    wi   = res_pc[5:2];
    whit = m_vld[wi] && (m_tag[wi] == res_pc[31:6]);
    if (res_vld) begin
      if (res_taken) begin
        m_vld[wi] = 1; m_dir[wi] = 1; m_tag[wi] = res_pc[31:6]; m_tgt[wi] = res_tgt;
      end else if (whit) begin
        m_dir[wi] = 0;
      end
    end
    m_pc = npc; m_src = nsrc;
  endtask

  task automatic compare(input string req);
    checks++;
    if (fetch_pc !== m_pc || fetch_src !== m_src) begin
      errors++;
      $display("FAIL %s: fetch_pc=%h src=%0d expected fetch_pc=%h src=%0d",
               req, fetch_pc, fetch_src, m_pc, m_src);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag_of(m_src));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic train(input logic [31:0] pc, input bit tk, input logic [31:0] tgt);
    res_vld = 1; res_pc = pc; res_taken = tk; res_tgt = tgt;
    tick();
    res_vld = 0;
  endtask

  task automatic jump(input logic [31:0] tgt);
    exe_redir_vld = 1; exe_redir_tgt = tgt;
    tick();
    exe_redir_vld = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_ctr[i] = 2'b01;
    model_reset();
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    compare("R1");                       // R1 reset value
    rst = 0;
    idle(4);                             // R2 sequential run
    // R3: taken entry steers fetch
    train(32'h44, 1, 32'h100);
    jump(32'h3C);
    idle(4);
    // R6: fast says taken, counter says not taken
    train(32'h88, 0, 32'h0);
    train(32'h88, 0, 32'h0);
    train(32'h88, 1, 32'h200);
    jump(32'h84);
    idle(4);
    // R6: fast says not taken, counter says taken
    train(32'hCC, 1, 32'h300);
    train(32'hCC, 1, 32'h300);
    train(32'hCC, 0, 32'h0);
    jump(32'hCC);
    idle(4);
    // R5 R7: aliased counter taken, target cache misses
    train(32'h510, 1, 32'h600);
    train(32'h510, 1, 32'h600);
    jump(32'h110);
    idle(4);
    // R8 then R9 over R8
    dec_redir_vld = 1; dec_redir_tgt = 32'h240;
    tick();
    exe_redir_vld = 1; exe_redir_tgt = 32'h3A0;
    tick();
    dec_redir_vld = 0; exe_redir_vld = 0;
    idle(2);
    // R5 saturation then one step down
    for (int i = 0; i < 5; i++) train(32'h88, 1, 32'h200);
    train(32'h88, 0, 32'h0);
    jump(32'h88);
    idle(4);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      exe_redir_vld = ($urandom % 16) == 0;
      exe_redir_tgt = ($urandom % 64) * 4;
      dec_redir_vld = ($urandom % 12) == 0;
      dec_redir_tgt = ($urandom % 64) * 4;
      res_vld   = ($urandom % 3) == 0;
      res_pc    = 32'h40 + ($urandom % 8) * 4 + ((($urandom % 4) == 0) ? 32'h400 : 32'h0);
      res_taken = $urandom % 2;
      res_tgt   = ($urandom % 64) * 4;
      tick();
    end
    exe_redir_vld = 0; dec_redir_vld = 0; res_vld = 0;
    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule